// File: doc/BRIEF.md
# CPU Idle and Power-Down Clock Controller

This block decides which clock domains of a small 8-bit microcontroller are allowed to run. Software writes a 4-bit control register holding an idle request, a power-down request and two general-purpose flags. A requested mode does not take effect on the write; it takes effect when the CPU retires an instruction, so the instruction that requested the mode is the last one executed before the CPU clock stops.

In idle only the CPU clock enable drops; peripherals and the oscillator keep running. Any enabled interrupt clears the idle bit in hardware and the CPU resumes. In power-down all three enables drop. Only an external wake interrupt or a reset ends power-down. A wake first restores the oscillator enable and waits a fixed stabilisation interval before the CPU and peripheral enables return. Power-down wins when both request bits are set, and leaving power-down clears both bits so that the CPU never falls into idle afterwards. Driving the active-low reset low forces the outputs to the run state at once, without waiting for a clock edge. The register is reset on the next clock edge.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, the register reads 0, `mode` is 0 (run) and `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1.
- R2: While `rst_n` is low, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, `mode` is 0 and `reg_rd_data[0]` is 0. These values appear without waiting for a clock edge.
- R3: In run mode, a write stores `reg_wr_data` and it reads back on `reg_rd_data` from the next cycle. Bit 0 is the idle request, bit 1 the power-down request, and bits 3:2 are general-purpose flags.
- R4: In run mode, a retire strobe with bit 0 set and bit 1 clear enters idle from the next cycle. Idle gives `mode` 1, `cpu_clk_en` 0, `per_clk_en` 1 and `osc_en` 1.
- R5: In idle, `irq_pending` returns the block to run on the next cycle. Bit 0 reads 0 and bits 3:2 are kept.
- R6: In run mode, a retire strobe with bit 1 set enters power-down from the next cycle. Power-down gives `mode` 2 and all three enables 0.
- R7: With bits 0 and 1 both set, a retire strobe enters power-down and not idle.
- R8: In power-down before a wake, `irq_pending` has no effect and the outputs are unchanged. Only `wake_irq` starts the exit.
- R9: The cycle after `wake_irq`, `osc_en` is 1 while `cpu_clk_en` and `per_clk_en` stay 0 for STAB_CYCLES (16) cycles. The block then returns to run with bits 1:0 cleared and bits 3:2 kept. It does not enter idle.
- R10: Writes made during idle or power-down leave `reg_rd_data` unchanged.
- R11: `mode` encodes run as 0, idle as 1 and power-down as 2, including during the stabilisation wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low reset; the register resets on a clock edge, the outputs are forced at once |
| reg_wr_en | input | 1 | Register write strobe from the CPU |
| reg_wr_data | input | 4 | Write data: bit 0 idle, bit 1 power-down, bits 3:2 flags |
| reg_rd_data | output | 4 | Current register contents |
| insn_retire | input | 1 | One-cycle strobe when the CPU retires an instruction |
| irq_pending | input | 1 | An enabled interrupt is pending |
| wake_irq | input | 1 | External wake interrupt |
| cpu_clk_en | output | 1 | Clock enable for the CPU domain |
| per_clk_en | output | 1 | Clock enable for the peripheral domain |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | 0 run, 1 idle, 2 power-down |

## Verification
The properties assume that `insn_retire` pulses only while the CPU clock runs. They also assume that the register is not written in the same cycle as a mode-entering retire. The stimulus therefore writes the register, waits a cycle and then issues the retire. Assertions that compare against the previous cycle are switched off while `rst_n` is low. The bench drops `rst_n` between clock edges only in the test for the immediate run state. It raises `rst_n` again before checking the next properties.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the power-mode controller.
// Assumes a 4-bit control register with the mode request bits in the low positions.
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_DOWN = 2'd2,
        ST_WAKE = 2'd3
    } pwr_state_e;

    localparam int CTRL_W   = 4;
    localparam int IDLE_BIT = 0;
    localparam int DOWN_BIT = 1;

    localparam logic [1:0] MODE_RUN  = 2'd0;
    localparam logic [1:0] MODE_IDLE = 2'd1;
    localparam logic [1:0] MODE_DOWN = 2'd2;
endpackage

// File: rtl/pwr_ctrl_reg.sv
`timescale 1ns/1ps
// Control register: software write port plus hardware clears of the mode bits.
// Assumes wr_allow is low whenever a hardware clear is requested.
module pwr_ctrl_reg #(
    parameter int W = pwr_mode_pkg::CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_allow,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         clr_idle,
    input  logic         clr_down,
    output logic [W-1:0] q
);
    import pwr_mode_pkg::*;

    // Store software writes in run, otherwise apply hardware clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_allow && wr_en) begin
            q <= wr_data;
        end else begin
            if (clr_idle) q[IDLE_BIT] <= 1'b0;
            if (clr_down) q[DOWN_BIT] <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_stab_timer.sv
`timescale 1ns/1ps
// Oscillator stabilisation counter: counts while run is high, done on the last cycle.
// Assumes STAB_CYCLES >= 1; the count restarts whenever run drops.
module pwr_stab_timer #(
    parameter int STAB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (STAB_CYCLES < 2) ? 1 : $clog2(STAB_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count cycles of the stabilisation wait, clearing when idle or finished.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
// Mode sequencer: run, idle, power-down and the stabilisation wait.
// Assumes request bits are sampled from the register value held before the retiring write.
module pwr_mode_fsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     insn_retire,
    input  logic                     irq_pending,
    input  logic                     wake_irq,
    input  logic                     idle_req,
    input  logic                     down_req,
    input  logic                     stab_done,
    output pwr_mode_pkg::pwr_state_e state,
    output logic                     clr_idle,
    output logic                     clr_down,
    output logic                     timer_run
);
    import pwr_mode_pkg::*;

    pwr_state_e nxt;

    // Choose the next state and the hardware clears of the request bits.
    always_comb begin
        nxt      = state;
        clr_idle = 1'b0;
        clr_down = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (insn_retire && down_req)      nxt = ST_DOWN;
                else if (insn_retire && idle_req) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (irq_pending) begin
                    nxt      = ST_RUN;
                    clr_idle = 1'b1;
                end
            end
            ST_DOWN: begin
                if (wake_irq) nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (stab_done) begin
                    nxt      = ST_RUN;
                    clr_idle = 1'b1;
                    clr_down = 1'b1;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    // Hold the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    assign timer_run = (state == ST_WAKE);
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
// Power-mode controller top: register, sequencer and stabilisation counter.
// Outputs are forced to the run state combinationally while rst_n is low.
module pwr_mode_ctrl #(
    parameter int STAB_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [3:0] reg_wr_data,
    output logic [3:0] reg_rd_data,
    input  logic       insn_retire,
    input  logic       irq_pending,
    input  logic       wake_irq,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic [1:0] mode
);
    import pwr_mode_pkg::*;

    pwr_state_e        state;
    logic [CTRL_W-1:0] ctrl_q;
    logic              clr_idle, clr_down, timer_run, stab_done;

    pwr_ctrl_reg #(.W(CTRL_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_allow (state == ST_RUN),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .clr_idle (clr_idle),
        .clr_down (clr_down),
        .q        (ctrl_q)
    );

    pwr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_retire (insn_retire),
        .irq_pending (irq_pending),
        .wake_irq    (wake_irq),
        .idle_req    (ctrl_q[IDLE_BIT]),
        .down_req    (ctrl_q[DOWN_BIT]),
        .stab_done   (stab_done),
        .state       (state),
        .clr_idle    (clr_idle),
        .clr_down    (clr_down),
        .timer_run   (timer_run)
    );

    pwr_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .done  (stab_done)
    );

    // Derive enables and mode code, overriding with run while reset is held.
    always_comb begin
        cpu_clk_en  = !rst_n || (state == ST_RUN);
        per_clk_en  = !rst_n || (state == ST_RUN) || (state == ST_IDLE);
        osc_en      = !rst_n || (state != ST_DOWN);
        reg_rd_data = ctrl_q;
        reg_rd_data[IDLE_BIT] = ctrl_q[IDLE_BIT] && rst_n;
        if (!rst_n)                                      mode = MODE_RUN;
        else if (state == ST_IDLE)                       mode = MODE_IDLE;
        else if (state == ST_DOWN || state == ST_WAKE)   mode = MODE_DOWN;
        else                                             mode = MODE_RUN;
    end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the power-mode controller, observing ports only.
// Assumes retire strobes occur only in run and not in the same cycle as a write.
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic [3:0] reg_rd_data,
    input logic       insn_retire,
    input logic       irq_pending,
    input logic       wake_irq,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic [1:0] mode
);
    AST_RESET_RUN: assert property (@(posedge clk) !rst_n |-> (cpu_clk_en && per_clk_en && osc_en && mode == 2'd0)); // R2
    AST_IDLE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n) mode == 2'd1 |-> (!cpu_clk_en && per_clk_en && osc_en)); // R4
    AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd0 && insn_retire && !reg_wr_en && reg_rd_data[1:0] == 2'b01) |=> mode == 2'd1); // R4
    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd1 && irq_pending) |=> (mode == 2'd0 && !reg_rd_data[0])); // R5
    AST_DOWN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2) |-> (!cpu_clk_en && !per_clk_en)); // R6
    AST_BOTH_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd0 && insn_retire && !reg_wr_en && reg_rd_data[1]) |=> (mode == 2'd2 && !osc_en)); // R7
    AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2 && !osc_en && !wake_irq) |=> (mode == 2'd2 && !osc_en)); // R8
    AST_DOWN_EXIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2) |=> (mode != 2'd0 || reg_rd_data[1:0] == 2'b00)); // R9
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd1 && !irq_pending) |=> $stable(reg_rd_data)); // R10
    AST_DOWN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2 && !osc_en) |=> $stable(reg_rd_data)); // R10
    AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'd3); // R11
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data),
    .insn_retire (insn_retire),
    .irq_pending (irq_pending),
    .wake_irq    (wake_irq),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en),
    .mode        (mode)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed checks.
module pwr_mode_ctrl_tb;
    localparam int STAB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [3:0] reg_wr_data = 4'd0;
    logic [3:0] reg_rd_data;
    logic       insn_retire = 1'b0;
    logic       irq_pending = 1'b0;
    logic       wake_irq = 1'b0;
    logic       cpu_clk_en, per_clk_en, osc_en;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    // reference model state: 0 run, 1 idle, 2 down, 3 wake
    int m_st = 0;
    int m_reg = 0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.STAB_CYCLES(STAB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .insn_retire(insn_retire), .irq_pending(irq_pending),
        .wake_irq(wake_irq), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .mode(mode)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Update the reference model on each clock edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_reg = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: begin
                    if (insn_retire && (m_reg & 2) != 0)      m_st = 2;
                    else if (insn_retire && (m_reg & 1) != 0) m_st = 1;
                    if (reg_wr_en) m_reg = int'(reg_wr_data);
                end
                1: if (irq_pending) begin m_reg = m_reg & 14; m_st = 0; end
                2: if (wake_irq) begin m_st = 3; m_cnt = 0; end
                default: begin
                    if (m_cnt == STAB - 1) begin m_st = 0; m_reg = m_reg & 12; m_cnt = 0; end
                    else m_cnt++;
                end
            endcase
        end
    end

    // Compare every output against the model between clock edges.
    always @(negedge clk) begin
        if (!done_flag) begin
            string rq;
            rq = (m_st == 1) ? "R4" : (m_st == 2) ? "R6" : (m_st == 3) ? "R9" : "R1";
            check(rq, "cpu_clk_en", int'(cpu_clk_en), (!rst_n || m_st == 0) ? 1 : 0);
            check(rq, "per_clk_en", int'(per_clk_en), (!rst_n || m_st <= 1) ? 1 : 0);
            check(rq, "osc_en", int'(osc_en), (!rst_n || m_st != 2) ? 1 : 0);
            check("R11", "mode", int'(mode), !rst_n ? 0 : (m_st >= 2 ? 2 : m_st));
            check("R3", "reg_rd_data", int'(reg_rd_data), rst_n ? m_reg : (m_reg & 14));
        end
    end

    task automatic tick();
        @(negedge clk); #2;
    endtask

    task automatic drive(input bit wr, input int d, input bit ret, input bit irq, input bit wk);
        reg_wr_en = wr; reg_wr_data = 4'(d); insn_retire = ret; irq_pending = irq; wake_irq = wk;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        finish_run();
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1", "mode after reset", int'(mode), 0);
        check("R1", "register after reset", int'(reg_rd_data), 0);
        check("R1", "enables after reset", int'({cpu_clk_en, per_clk_en, osc_en}), 7);
        // R3 write and read back
        drive(1, 12, 0, 0, 0); tick(); drive(0, 0, 0, 0, 0);
        check("R3", "flags read back", int'(reg_rd_data), 12);
        // R4 idle entry on retire
        drive(1, 13, 0, 0, 0); tick(); drive(0, 0, 0, 0, 0); tick();
        drive(0, 0, 1, 0, 0); tick(); drive(0, 0, 0, 0, 0);
        check("R4", "idle mode", int'(mode), 1);
        check("R4", "idle enables", int'({cpu_clk_en, per_clk_en, osc_en}), 3);
        // R10 write ignored during idle
        drive(1, 0, 0, 0, 0); tick(); drive(0, 0, 0, 0, 0); tick();
        check("R10", "write in idle ignored", int'(reg_rd_data), 13);
        // R5 interrupt exits idle, flags kept
        drive(0, 0, 0, 1, 0); tick(); drive(0, 0, 0, 0, 0);
        check("R5", "mode after interrupt", int'(mode), 0);
        check("R5", "register after interrupt", int'(reg_rd_data), 12);
        // R6 power-down entry
        drive(1, 6, 0, 0, 0); tick(); drive(0, 0, 0, 0, 0); tick();
        drive(0, 0, 1, 0, 0); tick(); drive(0, 0, 0, 0, 0);
        check("R6", "down mode", int'(mode), 2);
        check("R6", "down enables", int'({cpu_clk_en, per_clk_en, osc_en}), 0);
        // R8 interrupt ignored in power-down
        drive(0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) tick();
        drive(0, 0, 0, 0, 0);
        check("R8", "still down after irq", int'(mode), 2);
        check("R8", "osc still off after irq", int'(osc_en), 0);
        // R10 write ignored in power-down
        drive(1, 9, 0, 0, 0); tick(); drive(0, 0, 0, 0, 0); tick();
        check("R10", "write in down ignored", int'(reg_rd_data), 6);
        // R9 wake with stabilisation
        drive(0, 0, 0, 0, 1); tick(); drive(0, 0, 0, 0, 0);
        check("R9", "osc on after wake", int'(osc_en), 1);
        check("R9", "cpu still off after wake", int'(cpu_clk_en), 0);
        check("R11", "mode during stabilisation", int'(mode), 2);
        for (int i = 1; i < STAB; i++) tick();
        check("R9", "cpu off on last wait cycle", int'(cpu_clk_en), 0);
        tick();
        check("R9", "run after wait", int'(mode), 0);
        check("R9", "bits cleared after wake", int'(reg_rd_data), 4);
        // R7 both bits set goes to power-down, and no idle after wake
        drive(1, 3, 0, 0, 0); tick(); drive(0, 0, 0, 0, 0); tick();
        drive(0, 0, 1, 0, 0); tick(); drive(0, 0, 0, 0, 0);
        check("R7", "both bits pick down", int'(mode), 2);
        check("R7", "osc off with both bits", int'(osc_en), 0);
        drive(0, 0, 0, 0, 1); tick(); drive(0, 0, 0, 0, 0);
        for (int i = 0; i < STAB + 2; i++) tick();
        check("R7", "no idle after down exit", int'(mode), 0);
        check("R7", "request bits clear", int'(reg_rd_data), 0);
        // R2 reset forces run between edges
        drive(1, 1, 0, 0, 0); tick(); drive(0, 0, 0, 0, 0); tick();
        drive(0, 0, 1, 0, 0); tick(); drive(0, 0, 0, 0, 0);
        check("R4", "idle before reset", int'(mode), 1);
        #3 rst_n = 1'b0;
        #1;
        check("R2", "cpu enable under reset", int'(cpu_clk_en), 1);
        check("R2", "mode under reset", int'(mode), 0);
        check("R2", "idle bit under reset", int'(reg_rd_data[0]), 0);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1", "register after reset pulse", int'(reg_rd_data), 0);
        tick();
        finish_run();
    end
endmodule